// File: doc/BRIEF.md
# Vector Load Address Sequencer

This block accepts one vectorized load operation and expands it into a series of single-element memory reads, each followed by a write of the returned datum into the register file. The operation arrives as a one-cycle start pulse, together with a vector length, three register numbers (destination, base, index), a signed immediate, a flag choosing immediate or indexed form, a per-operand vector/scalar flag, and a flag for element-strided addressing. Base and index values are fetched through one combinational register-file read port.

The addressing pattern follows from which operands are flagged as vectors. One opcode can therefore yield a contiguous load, an element-strided load, a gather through a vector of address registers, a splat of one address into many destinations, or a select that computes many addresses but keeps only the final result. Requests leave on a valid/ready channel, one at a time and in rising element order. A busy flag covers the whole operation and a done pulse marks its end.

Top module: `vload_seq`

## Requirements
- R1: Immediate form, vector destination, scalar base, strided flag clear: element i is read at R[RA] + imm + 8*i (element width 8 bytes) and written to register RT+i.
- R2: Immediate form, vector destination, scalar base, strided flag set: element i is read at R[RA] + imm*i and written to RT+i.
- R3: Immediate form, vector destination, vector base: element i is read at R[RA+i] + imm and written to RT+i.
- R4: Select: scalar destination with a vector source (immediate form with vector base, or indexed form with any vector source) issues VL requests addressed as the matching vector case, and writes only the last returned datum, once, into RT.
- R5: All-scalar operation (in immediate form the index flag is ignored) issues exactly one request, at R[RA] + imm or R[RA] + R[RB], writes RT once, and ignores VL.
- R6: Indexed form, vector destination, vector RA, scalar RB: element i is read at R[RA+i] + R[RB] and written to RT+i.
- R7: Indexed form, vector destination, vector RB (RA either scalar or vector): element i is read at R[RA] + R[RB] + 8*i and written to RT+i.
- R8: Indexed form, vector destination, RA and RB both scalar: every element is read at R[RA] + R[RB] and written to RT+i.
- R9: With VL = 0 and any operand flagged vector, done is high in the cycle after start is sampled, with no request and no register write.
- R10: Requests are issued in increasing element order with at most one outstanding; the address holds steady while valid waits for ready.
- R11: busy is high from the cycle after an accepted start through the done cycle; done lasts one cycle; a start while busy is ignored.
- R12: Register numbers RT+i and RA+i wrap modulo the register count (32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| vl | input | 7 | Vector length, 0..64 |
| rt_num | input | 5 | Destination register number |
| ra_num | input | 5 | Base register number |
| rb_num | input | 5 | Index register number |
| imm | input | 64 | Signed immediate offset |
| idx_form | input | 1 | 1 = indexed form, 0 = immediate form |
| rt_vec | input | 1 | Destination is a vector |
| ra_vec | input | 1 | Base is a vector |
| rb_vec | input | 1 | Index is a vector |
| elem_strided | input | 1 | Element-strided immediate addressing |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 64 | Register-file read data (same cycle) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Request byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Returned data |
| wb_en | output | 1 | Register write enable |
| wb_addr | output | 5 | Register write number |
| wb_data | output | 64 | Register write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the select mode, where several requests go out but only the last response may land in a register, combined with a memory side that stalls ready and varies response latency so that the one-outstanding rule and address hold are actually stressed. The bench drives ready low on a repeating pattern and alternates response delay, while a scoreboard queues every expected address and every expected write in order, so a stray write from a non-final select element or an out-of-order request is caught at once. Register-number wrap is reached by placing both destination and base near the top of the register file with a vector length that crosses the end.

// File: rtl/vls_pkg.sv
// Shared types for the vector load sequencer.
// Assumes nothing beyond the standard language.
package vls_pkg;
    // How element addresses advance from one element to the next.
    typedef enum logic [1:0] {
        AK_UNIT   = 2'd0,   // contiguous, step = element bytes
        AK_ELEM   = 2'd1,   // step = immediate
        AK_GATHER = 2'd2,   // base re-read per element
        AK_SPLAT  = 2'd3    // same address for all elements
    } addr_kind_e;

    // Decoded plan for one operation.
    typedef struct packed {
        addr_kind_e kind;
        logic       last_only;   // write only the final datum (select)
        logic       single;      // exactly one element, VL ignored
        logic       idx_form;    // index register supplies the offset
    } op_plan_t;
endpackage

// File: rtl/vls_decode.sv
// Mode decoder: maps operand vector flags and form to an addressing plan.
// Purely combinational; assumes flags are valid when start is sampled.
module vls_decode
    import vls_pkg::*;
(
    input  logic     idx_form,
    input  logic     rt_vec,
    input  logic     ra_vec,
    input  logic     rb_vec,
    input  logic     elem_strided,
    output op_plan_t plan
);
    // Select addressing kind and writeback policy from the operand flags.
    always_comb begin
        plan           = '0;
        plan.idx_form  = idx_form;
        plan.last_only = !rt_vec;
        if (!idx_form) begin
            if (ra_vec) begin
                plan.kind = AK_GATHER;
            end else if (rt_vec) begin
                plan.kind = elem_strided ? AK_ELEM : AK_UNIT;
            end else begin
                plan.kind   = AK_UNIT;
                plan.single = 1'b1;
            end
        end else begin
            if (ra_vec && !rb_vec) begin
                plan.kind = AK_GATHER;
            end else if (rb_vec) begin
                plan.kind = AK_UNIT;
            end else begin
                plan.kind   = AK_SPLAT;
                plan.single = !rt_vec;
            end
        end
    end
endmodule

// File: rtl/vls_addr_gen.sv
// Address generator: holds base, offset and accumulated stride, and
// presents their sum as the request address. Loads are strobed by the
// controller; assumes rf_rdata is valid in the cycle a load strobe is high.
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int EBYTES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  addr_kind_e      kind,
    input  logic            idx_form,
    input  logic [XLEN-1:0] imm,
    input  logic            ld_off,
    input  logic            ld_base,
    input  logic            step,
    input  logic [XLEN-1:0] rf_rdata,
    output logic [XLEN-1:0] addr
);
    localparam logic [XLEN-1:0] UNIT_STEP = XLEN'(EBYTES);

    logic [XLEN-1:0] base_q;
    logic [XLEN-1:0] off_q;
    logic [XLEN-1:0] acc_q;
    logic [XLEN-1:0] step_q;

    // Capture operands at start and advance the stride accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            off_q  <= '0;
            acc_q  <= '0;
            step_q <= '0;
        end else if (init) begin
            off_q  <= (idx_form || kind == AK_ELEM) ? '0 : imm;
            acc_q  <= '0;
            case (kind)
                AK_UNIT: step_q <= UNIT_STEP;
                AK_ELEM: step_q <= imm;
                default: step_q <= '0;
            endcase
        end else begin
            if (ld_off)  off_q  <= rf_rdata;
            if (ld_base) base_q <= rf_rdata;
            if (step)    acc_q  <= acc_q + step_q;
        end
    end

    // Request address is the sum of the three terms.
    always_comb addr = base_q + off_q + acc_q;
endmodule

// File: rtl/vls_ctrl.sv
// Sequencing controller: walks elements in order, drives register reads,
// the request handshake and writebacks. One request outstanding at a time;
// assumes a response arrives only after its request was accepted.
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int RW  = 5,
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl,
    input  logic [RW-1:0]  rt_num,
    input  logic [RW-1:0]  ra_num,
    input  logic [RW-1:0]  rb_num,
    input  op_plan_t       plan_in,
    output logic [RW-1:0]  rf_raddr,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    input  logic           mem_rsp_valid,
    output logic           wb_en,
    output logic [RW-1:0]  wb_addr,
    output logic           busy,
    output logic           done,
    output logic           init,
    output logic           ld_off,
    output logic           ld_base,
    output logic           step
);
    typedef enum logic [2:0] {
        S_IDLE, S_RDB, S_RDA, S_REQ, S_WAIT, S_FIN
    } state_e;

    state_e         state_q;
    op_plan_t       plan_q;
    logic [VLW-1:0] cnt_q;
    logic [VLW-1:0] idx_q;
    logic [RW-1:0]  rt_q;
    logic [RW-1:0]  ra_q;
    logic [RW-1:0]  rb_q;
    logic [VLW-1:0] cnt_d;
    logic           last;
    logic           gather;

    always_comb cnt_d  = plan_in.single ? VLW'(1) : vl;
    always_comb init   = start && (state_q == S_IDLE);
    always_comb last   = (idx_q == cnt_q - VLW'(1));
    always_comb gather = (plan_q.kind == AK_GATHER);

    // State, element counter and latched operation fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            plan_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            rt_q    <= '0;
            ra_q    <= '0;
            rb_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    plan_q <= plan_in;
                    cnt_q  <= cnt_d;
                    idx_q  <= '0;
                    rt_q   <= rt_num;
                    ra_q   <= ra_num;
                    rb_q   <= rb_num;
                    if (cnt_d == '0)          state_q <= S_FIN;
                    else if (plan_in.idx_form) state_q <= S_RDB;
                    else                       state_q <= S_RDA;
                end
                S_RDB:  state_q <= S_RDA;
                S_RDA:  state_q <= S_REQ;
                S_REQ:  if (mem_req_ready) state_q <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    if (last) begin
                        state_q <= S_FIN;
                    end else begin
                        idx_q   <= idx_q + VLW'(1);
                        state_q <= gather ? S_RDA : S_REQ;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Register read address: index in RDB, base (stepped for gather) in RDA.
    always_comb begin
        if (state_q == S_RDB) rf_raddr = rb_q;
        else                  rf_raddr = ra_q + (gather ? RW'(idx_q) : '0);
    end

    // Handshake, writeback and datapath strobes.
    always_comb begin
        mem_req_valid = (state_q == S_REQ);
        wb_en   = (state_q == S_WAIT) && mem_rsp_valid && (!plan_q.last_only || last);
        wb_addr = rt_q + (plan_q.last_only ? '0 : RW'(idx_q));
        ld_off  = (state_q == S_RDB);
        ld_base = (state_q == S_RDA);
        step    = (state_q == S_WAIT) && mem_rsp_valid && !last;
        busy    = (state_q != S_IDLE);
        done    = (state_q == S_FIN);
    end
endmodule

// File: rtl/vload_seq.sv
// Vector load sequencer top: decodes the operand flags, then issues one
// memory read per element and writes results back to the register file.
// Assumes NREG is a power of two and a same-cycle register read port.
module vload_seq
    import vls_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREG   = 32,
    parameter int MAXVL  = 64,
    parameter int EBYTES = 8,
    localparam int RW    = $clog2(NREG),
    localparam int VLW   = $clog2(MAXVL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [VLW-1:0]  vl,
    input  logic [RW-1:0]   rt_num,
    input  logic [RW-1:0]   ra_num,
    input  logic [RW-1:0]   rb_num,
    input  logic [XLEN-1:0] imm,
    input  logic            idx_form,
    input  logic            rt_vec,
    input  logic            ra_vec,
    input  logic            rb_vec,
    input  logic            elem_strided,
    output logic [RW-1:0]   rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            wb_en,
    output logic [RW-1:0]   wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            busy,
    output logic            done
);
    op_plan_t plan;
    logic     init, ld_off, ld_base, step;

    vls_decode u_dec (
        .idx_form     (idx_form),
        .rt_vec       (rt_vec),
        .ra_vec       (ra_vec),
        .rb_vec       (rb_vec),
        .elem_strided (elem_strided),
        .plan         (plan)
    );

    vls_ctrl #(.RW(RW), .VLW(VLW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .vl            (vl),
        .rt_num        (rt_num),
        .ra_num        (ra_num),
        .rb_num        (rb_num),
        .plan_in       (plan),
        .rf_raddr      (rf_raddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .wb_en         (wb_en),
        .wb_addr       (wb_addr),
        .busy          (busy),
        .done          (done),
        .init          (init),
        .ld_off        (ld_off),
        .ld_base       (ld_base),
        .step          (step)
    );

    vls_addr_gen #(.XLEN(XLEN), .EBYTES(EBYTES)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (init),
        .kind     (plan.kind),
        .idx_form (idx_form),
        .imm      (imm),
        .ld_off   (ld_off),
        .ld_base  (ld_base),
        .step     (step),
        .rf_rdata (rf_rdata),
        .addr     (mem_req_addr)
    );

    // Returned data goes straight to the register write port.
    always_comb wb_data = mem_rsp_data;
endmodule

// File: rtl/vload_seq_chk.sv
// Protocol checker for vload_seq, attached by bind. Observes ports only.
module vload_seq_chk #(
    parameter int XLEN = 64,
    parameter int RW   = 5,
    parameter int VLW  = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VLW-1:0]  vl,
    input logic            idx_form,
    input logic            rt_vec,
    input logic            ra_vec,
    input logic            rb_vec,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            mem_rsp_valid,
    input logic            wb_en,
    input logic [RW-1:0]   wb_addr,
    input logic            busy,
    input logic            done
);
    logic outst_q;
    logic vec_op;

    // Track whether an accepted request still awaits its response.
    always_ff @(posedge clk) begin
        if (!rst_n)                             outst_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
        else if (mem_rsp_valid)                 outst_q <= 1'b0;
    end

    always_comb vec_op = rt_vec || ra_vec || (idx_form && rb_vec);

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_req_valid);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !wb_en));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_zero_vl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl == '0 && vec_op) |=> (done && !mem_req_valid && !wb_en));
    p_wb_known_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> !$isunknown(wb_addr));
endmodule

bind vload_seq vload_seq_chk #(.XLEN(XLEN), .RW(RW), .VLW(VLW)) u_chk (.*);

// File: tb/vload_seq_tb.sv
// Scoreboard bench: the driver task queues expected requests and writes,
// a monitor pops and compares them as the design produces them.
module vload_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [4:0]  rt_num = '0, ra_num = '0, rb_num = '0;
    logic [63:0] imm = '0;
    logic        idx_form = 1'b0, rt_vec = 1'b0, ra_vec = 1'b0, rb_vec = 1'b0, elem_strided = 1'b0;
    logic [4:0]  rf_raddr;
    logic [63:0] rf_rdata;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        wb_en;
    logic [4:0]  wb_addr;
    logic [63:0] wb_data;
    logic        busy, done;

    logic [63:0] rf [32];
    assign rf_rdata = rf[rf_raddr];

    int checks = 0, errors = 0, done_cnt = 0;
    bit finished = 1'b0;
    string cur_tag = "reset";
    logic [63:0] exp_req[$];
    logic [4:0]  exp_wa[$];
    logic [63:0] exp_wd[$];
    logic [63:0] rsp_q[$];
    int          rsp_dly[$];
    int          lat_sel = 0;

    vload_seq u_dut (.*);

    always #4 clk = ~clk;

    function automatic logic [63:0] memf(logic [63:0] a);
        return a ^ 64'hC3C3_0000_0000_F0F0;
    endfunction

    task automatic chk(bit ok, string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // Monitor: just before each rising edge, compare handshakes and writes.
    initial forever begin
        @(posedge clk);
        #7;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (exp_req.size() == 0) begin
                chk(0, $sformatf("%s R10 unexpected request got %h exp none", cur_tag, mem_req_addr));
            end else begin
                logic [63:0] e;
                e = exp_req.pop_front();
                chk(mem_req_addr == e, $sformatf("%s R10 request addr got %h exp %h", cur_tag, mem_req_addr, e));
            end
            rsp_q.push_back(mem_req_addr);
            rsp_dly.push_back(lat_sel);
            lat_sel = 1 - lat_sel;
        end
        if (rst_n && wb_en) begin
            if (exp_wa.size() == 0) begin
                chk(0, $sformatf("%s unexpected write got r%0d exp none", cur_tag, wb_addr));
            end else begin
                logic [4:0]  ea;
                logic [63:0] ed;
                ea = exp_wa.pop_front();
                ed = exp_wd.pop_front();
                chk(wb_addr == ea && wb_data == ed,
                    $sformatf("%s write got r%0d/%h exp r%0d/%h", cur_tag, wb_addr, wb_data, ea, ed));
            end
        end
        if (rst_n && done) done_cnt++;
    end

    // Memory responder: ready pattern and variable response latency.
    initial begin
        int rc = 0;
        forever begin
            @(negedge clk);
            rc++;
            mem_req_ready = (rc % 3) != 0;
            mem_rsp_valid = 1'b0;
            if (rsp_q.size() > 0) begin
                if (rsp_dly[0] == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = memf(rsp_q.pop_front());
                    void'(rsp_dly.pop_front());
                end else begin
                    rsp_dly[0] = rsp_dly[0] - 1;
                end
            end
        end
    end

    // Driver: compute expectations from the requirements, then launch.
    task automatic run_op(string tag, int n, int rt, int ra, int rb, logic [63:0] im,
                          bit idx, bit rtv, bit rav, bit rbv, bit els, bit glitch);
        bit single;
        int cnt;
        int d0;
        int t;
        logic [63:0] a;
        cur_tag = tag;
        single = !rtv && !rav && (!idx || !rbv);
        cnt = single ? 1 : n;
        for (int i = 0; i < cnt; i++) begin
            if (!idx) begin
                if (rav)              a = rf[(ra + i) % 32] + im;
                else if (rtv && els)  a = rf[ra] + im * 64'(i);
                else                  a = rf[ra] + im + 64'(8 * i);
            end else begin
                if (rav && !rbv)      a = rf[(ra + i) % 32] + rf[rb];
                else if (rbv)         a = rf[ra] + rf[rb] + 64'(8 * i);
                else                  a = rf[ra] + rf[rb];
            end
            exp_req.push_back(a);
            if (rtv) begin
                exp_wa.push_back(5'((rt + i) % 32));
                exp_wd.push_back(memf(a));
            end else if (i == cnt - 1) begin
                exp_wa.push_back(5'(rt));
                exp_wd.push_back(memf(a));
            end
        end
        d0 = done_cnt;
        @(negedge clk);
        vl = 7'(n); rt_num = 5'(rt); ra_num = 5'(ra); rb_num = 5'(rb); imm = im;
        idx_form = idx; rt_vec = rtv; ra_vec = rav; rb_vec = rbv; elem_strided = els;
        start = 1'b1;
        @(posedge clk);
        #3;
        chk(busy == 1'b1, $sformatf("%s R11 busy after start got %b exp 1", tag, busy));
        if (cnt == 0)
            chk(done == 1'b1, $sformatf("%s R9 done one cycle after start got %b exp 1", tag, done));
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin
            repeat (4) @(negedge clk);
            vl = 7'd5; rt_num = 5'd1; ra_num = 5'd2; imm = 64'h40; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        chk(done_cnt == d0 + 1, $sformatf("%s R11 done count got %0d exp %0d", tag, done_cnt - d0, 1));
        repeat (6) @(negedge clk);
        chk(exp_req.size() == 0, $sformatf("%s R10 missing requests got %0d left exp 0", tag, exp_req.size()));
        chk(exp_wa.size() == 0, $sformatf("%s missing writes got %0d left exp 0", tag, exp_wa.size()));
        chk(busy == 1'b0, $sformatf("%s R11 idle after done got %b exp 0", tag, busy));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 64'h1000_0000 + 64'(i) * 64'h100;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(busy == 0 && done == 0 && mem_req_valid == 0 && wb_en == 0,
            $sformatf("reset R11 outputs got %b%b%b%b exp 0000", busy, done, mem_req_valid, wb_en));
        //        tag     vl rt  ra  rb imm        idx rtv rav rbv els glitch
        run_op("R1 unit",     4,  8,  3,  0, 64'd16,     0, 1, 0, 0, 0, 0);
        run_op("R2 elem",     3,  4,  5,  0, -64'sd24,   0, 1, 0, 0, 1, 0);
        run_op("R3 gather",   3, 12, 10,  0, 64'd4,      0, 1, 1, 0, 0, 0);
        run_op("R4 sel imm",  3,  6, 14,  0, 64'd8,      0, 0, 1, 0, 0, 0);
        run_op("R5 single",   5,  7,  9,  0, 64'd32,     0, 0, 0, 1, 0, 0);
        run_op("R5 single ix",6,  2,  3,  4, 64'd0,      1, 0, 0, 0, 0, 0);
        run_op("R6 gather ix",4, 16,  6,  1, 64'd0,      1, 1, 1, 0, 0, 0);
        run_op("R7 contig",   3, 20,  2,  5, 64'd0,      1, 1, 0, 1, 0, 0);
        run_op("R7 contig vv",2, 22,  3,  6, 64'd0,      1, 1, 1, 1, 0, 0);
        run_op("R8 splat",    3, 24,  7,  8, 64'd0,      1, 1, 0, 0, 0, 0);
        run_op("R4 sel ix",   4,  9, 11,  2, 64'd0,      1, 0, 1, 0, 0, 0);
        run_op("R9 zero vl",  0,  5,  5,  0, 64'd8,      0, 1, 0, 0, 0, 0);
        run_op("R12 wrap",    4, 30, 30,  0, 64'd0,      0, 1, 1, 0, 0, 0);
        run_op("R11 ignore",  4, 10,  1,  0, 64'd0,      0, 1, 0, 0, 0, 1);
        summary();
    end
endmodule